// File: doc/BRIEF.md
# Reorder Buffer with Precise Traps

This block keeps instructions in program order between rename and retirement in an out-of-order core. Dispatch writes one renamed instruction per cycle into a circular buffer, carrying its destination physical tag and its PC. Execution units later broadcast a destination tag with status flags; the matching entry is marked done, and may also be marked as faulting or as a wrongly predicted branch. Retirement then hands destination tags, oldest first, to the architectural map and free list.

A faulting instruction is held at the oldest position and reported with its PC, while retirement and dispatch stop, so the architectural state covers exactly the instructions before it. The surrounding control clears the buffer with a restart pulse once the trap is handled. A branch that completes as mispredicted removes every younger entry in the same cycle, long before the branch itself retires. Operand values are not kept here; they live in the physical register file.

Top module: `rob_core`

## Requirements
- R1: After reset the buffer is empty: `alloc_ready` is 1 and `commit_valid`, `exc_valid` and `flush` are 0.
- R2: An instruction is accepted in a cycle where `alloc_valid` and `alloc_ready` are both 1, and entries keep acceptance order; with DEPTH entries held and no retirement in that cycle, `alloc_ready` is 0 and nothing is accepted.
- R3: `commit_valid` is 1, with `commit_tag` giving the oldest entry's destination tag, exactly when the oldest entry is done without a fault; that entry leaves at the clock edge, so retirement is strictly in acceptance order, at most one per cycle, and no earlier than the cycle after its completion was presented.
- R4: A completion (`cmp_valid` = 1) whose `cmp_tag` equals the destination tag of a held entry marks that entry done at the next edge; a tag matching no held entry changes nothing.
- R5: A fault flag on a younger entry is not reported; once the oldest entry is done and flagged, `exc_valid` is 1 and `exc_pc` gives its PC, and that entry never retires.
- R6: While `exc_valid` is 1, `commit_valid` and `alloc_ready` are 0 and `exc_pc` holds its value until restart.
- R7: A `restart` pulse empties the buffer at the next edge, returning every output to its reset value.
- R8: A completion with `cmp_mispred` = 1 that matches a held entry raises `flush` in that same cycle and removes every younger entry at the edge; the branch and all older entries stay and later retire normally, and the next accepted instruction follows the branch.
- R9: In a cycle where `flush` is 1, `alloc_ready` is 0, so no wrong-path instruction is accepted then.
- R10: When the buffer holds DEPTH entries and the oldest retires in the same cycle, `alloc_ready` is 1 and a new instruction is accepted alongside the retirement.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| alloc_valid | input | 1 | Dispatch offers an instruction |
| alloc_tag | input | TAG_W | Destination physical tag of the offered instruction |
| alloc_pc | input | PC_W | PC of the offered instruction |
| alloc_ready | output | 1 | Buffer accepts the offered instruction this cycle |
| cmp_valid | input | 1 | Completion broadcast present |
| cmp_tag | input | TAG_W | Destination tag of the completing instruction |
| cmp_exc | input | 1 | Completing instruction raised a fault |
| cmp_mispred | input | 1 | Completing instruction is a mispredicted branch |
| commit_valid | output | 1 | Oldest entry retires this cycle |
| commit_tag | output | TAG_W | Destination tag of the retiring entry |
| exc_valid | output | 1 | Oldest entry is a completed faulting instruction |
| exc_pc | output | PC_W | PC of the faulting instruction |
| flush | output | 1 | Younger entries are squashed at this edge |
| restart | input | 1 | Clears the whole buffer |

## Verification
The bench fills the buffer to capacity and retires and accepts in the same cycle; a design that judged fullness without looking at retirement would stall there, and one that mixed up the wrap bit would lose or duplicate an entry. Completions arrive out of order and with unknown tags, so a design retiring anything other than the oldest done entry, or matching a stale tag, diverges from the queue model at once. Mispredicts are placed behind the wrap point and paired with a dispatch attempt, which catches a wrong new tail, a squash of the branch itself, or a wrong-path instruction slipping in. A fault posted on a younger entry must stay silent until the older work retires, after which retirement and dispatch must freeze until restart.

// File: rtl/rob_pkg.sv
package rob_pkg;

    // Condition of the oldest slot, as seen by retirement
    typedef enum logic [1:0] {
        HS_EMPTY  = 2'd0,
        HS_WAIT   = 2'd1,
        HS_RETIRE = 2'd2,
        HS_TRAP   = 2'd3
    } head_state_e;

endpackage

// File: rtl/rob_head_eval.sv
module rob_head_eval
    import rob_pkg::*;
(
    input  logic        head_valid,
    input  logic        head_done,
    input  logic        head_exc,
    output head_state_e state
);

    always_comb begin
        if (!head_valid) begin
            state = HS_EMPTY;
        end else if (!head_done) begin
            state = HS_WAIT;
        end else if (head_exc) begin
            state = HS_TRAP;
        end else begin
            state = HS_RETIRE;
        end
    end

endmodule

// File: rtl/rob_tag_match.sv
module rob_tag_match #(
    parameter int DEPTH = 8,
    parameter int TAG_W = 6,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0]       valid_vec,
    input  logic [DEPTH*TAG_W-1:0] tag_flat,
    input  logic                   probe_valid,
    input  logic [TAG_W-1:0]       probe_tag,
    output logic                   hit,
    output logic [IDX_W-1:0]       hit_idx
);

    logic [DEPTH-1:0] match;

    for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
        assign match[i] = probe_valid && valid_vec[i]
                          && (tag_flat[i*TAG_W +: TAG_W] == probe_tag);
    end

    // lowest matching slot wins; tags are unique in flight
    always_comb begin
        hit_idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (match[i]) begin
                hit_idx = IDX_W'(i);
            end
        end
    end

    assign hit = |match;

endmodule

// File: rtl/rob_flush_mask.sv
module rob_flush_mask #(
    parameter int DEPTH = 8,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int PTR_W = IDX_W + 1
) (
    input  logic [DEPTH-1:0] valid_vec,
    input  logic [PTR_W-1:0] head_ptr,
    input  logic [IDX_W-1:0] br_idx,
    output logic [DEPTH-1:0] squash_vec,
    output logic [PTR_W-1:0] new_tail
);

    logic [IDX_W-1:0] head_idx;
    logic [IDX_W-1:0] br_age;
    logic             br_wrap;

    assign head_idx = head_ptr[IDX_W-1:0];
    assign br_age   = br_idx - head_idx;

    // distance from the oldest slot decides who is younger than the branch
    for (genvar j = 0; j < DEPTH; j++) begin : g_age
        logic [IDX_W-1:0] slot_age;
        assign slot_age      = IDX_W'(j) - head_idx;
        assign squash_vec[j] = valid_vec[j] && (slot_age > br_age);
    end

    // a branch stored below the head index sits on the next lap
    assign br_wrap  = (br_idx >= head_idx) ? head_ptr[IDX_W] : ~head_ptr[IDX_W];
    assign new_tail = {br_wrap, br_idx} + PTR_W'(1);

endmodule

// File: rtl/rob_core.sv
module rob_core
    import rob_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int TAG_W = 6,
    parameter int PC_W  = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc_valid,
    input  logic [TAG_W-1:0] alloc_tag,
    input  logic [PC_W-1:0]  alloc_pc,
    output logic             alloc_ready,
    input  logic             cmp_valid,
    input  logic [TAG_W-1:0] cmp_tag,
    input  logic             cmp_exc,
    input  logic             cmp_mispred,
    output logic             commit_valid,
    output logic [TAG_W-1:0] commit_tag,
    output logic             exc_valid,
    output logic [PC_W-1:0]  exc_pc,
    output logic             flush,
    input  logic             restart
);

    localparam int IDX_W = $clog2(DEPTH);
    localparam int PTR_W = IDX_W + 1;

    typedef struct packed {
        logic             valid;
        logic             done;
        logic             exc;
        logic [TAG_W-1:0] tag;
        logic [PC_W-1:0]  pc;
    } slot_t;

    typedef struct packed {
        slot_t [DEPTH-1:0] slot;
        logic  [PTR_W-1:0] head;
        logic  [PTR_W-1:0] tail;
    } state_t;

    state_t st_q, st_d;

    logic [DEPTH-1:0]       valid_vec;
    logic [DEPTH*TAG_W-1:0] tag_flat;
    logic                   hit;
    logic [IDX_W-1:0]       hit_idx;
    logic [DEPTH-1:0]       squash_vec;
    logic [PTR_W-1:0]       flush_tail;
    logic [IDX_W-1:0]       head_idx;
    logic [IDX_W-1:0]       tail_idx;
    logic                   full;
    logic                   commit_fire;
    logic                   alloc_fire;
    head_state_e            hs;

    assign head_idx = st_q.head[IDX_W-1:0];
    assign tail_idx = st_q.tail[IDX_W-1:0];
    assign full     = (head_idx == tail_idx) && (st_q.head[IDX_W] != st_q.tail[IDX_W]);

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            valid_vec[i]                 = st_q.slot[i].valid;
            tag_flat[i*TAG_W +: TAG_W]   = st_q.slot[i].tag;
        end
    end

    rob_tag_match #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u_match (
        .valid_vec   (valid_vec),
        .tag_flat    (tag_flat),
        .probe_valid (cmp_valid),
        .probe_tag   (cmp_tag),
        .hit         (hit),
        .hit_idx     (hit_idx)
    );

    rob_flush_mask #(.DEPTH(DEPTH)) u_squash (
        .valid_vec  (valid_vec),
        .head_ptr   (st_q.head),
        .br_idx     (hit_idx),
        .squash_vec (squash_vec),
        .new_tail   (flush_tail)
    );

    rob_head_eval u_head (
        .head_valid (st_q.slot[head_idx].valid),
        .head_done  (st_q.slot[head_idx].done),
        .head_exc   (st_q.slot[head_idx].exc),
        .state      (hs)
    );

    assign commit_fire  = (hs == HS_RETIRE);
    assign exc_valid    = (hs == HS_TRAP);
    assign flush        = cmp_valid && hit && cmp_mispred;
    assign alloc_ready  = !exc_valid && !flush && (!full || commit_fire);
    assign alloc_fire   = alloc_valid && alloc_ready && !restart;
    assign commit_valid = commit_fire;
    assign commit_tag   = st_q.slot[head_idx].tag;
    assign exc_pc       = st_q.slot[head_idx].pc;

    always_comb begin
        st_d = st_q;

        // completion broadcast
        if (cmp_valid && hit) begin
            st_d.slot[hit_idx].done = 1'b1;
            st_d.slot[hit_idx].exc  = st_q.slot[hit_idx].exc | cmp_exc;
        end

        // squash everything behind a mispredicted branch
        if (flush) begin
            for (int j = 0; j < DEPTH; j++) begin
                if (squash_vec[j]) begin
                    st_d.slot[j].valid = 1'b0;
                end
            end
            st_d.tail = flush_tail;
        end

        // in-order retirement
        if (commit_fire) begin
            st_d.slot[head_idx].valid = 1'b0;
            st_d.head                 = st_q.head + PTR_W'(1);
        end

        // dispatch; never coincides with a flush
        if (alloc_fire) begin
            st_d.slot[tail_idx] = '{valid: 1'b1, done: 1'b0, exc: 1'b0,
                                    tag: alloc_tag, pc: alloc_pc};
            st_d.tail           = st_q.tail + PTR_W'(1);
        end

        if (restart) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/rob_core_chk.sv
module rob_core_chk #(
    parameter int PC_W = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            alloc_ready,
    input logic            cmp_valid,
    input logic            cmp_mispred,
    input logic            commit_valid,
    input logic            exc_valid,
    input logic [PC_W-1:0] exc_pc,
    input logic            flush,
    input logic            restart
);

    // R6: a pending trap freezes retirement and dispatch
    a_r6_trap_freezes: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid |-> (!commit_valid && !alloc_ready));

    // R6: the reported PC holds until restart
    a_r6_exc_pc_held: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_valid && !restart) |=> (exc_valid && $stable(exc_pc)));

    // R7: restart leaves nothing to retire or report
    a_r7_restart_empties: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (!commit_valid && !exc_valid && alloc_ready));

    // R8: a squash only comes from a mispredicted completion
    a_r8_flush_source: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> (cmp_valid && cmp_mispred));

    // R9: no wrong-path dispatch in a squash cycle
    a_r9_no_alloc_on_flush: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> !alloc_ready);

endmodule

bind rob_core rob_core_chk #(.PC_W(PC_W)) u_rob_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .alloc_ready  (alloc_ready),
    .cmp_valid    (cmp_valid),
    .cmp_mispred  (cmp_mispred),
    .commit_valid (commit_valid),
    .exc_valid    (exc_valid),
    .exc_pc       (exc_pc),
    .flush        (flush),
    .restart      (restart)
);

// File: tb/tb_rob_core.sv
`timescale 1ns/1ps
module tb_rob_core;

    localparam int DEPTH = 8;
    localparam int TAG_W = 6;
    localparam int PC_W  = 32;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             alloc_valid = 1'b0;
    logic [TAG_W-1:0] alloc_tag = '0;
    logic [PC_W-1:0]  alloc_pc = '0;
    logic             alloc_ready;
    logic             cmp_valid = 1'b0;
    logic [TAG_W-1:0] cmp_tag = '0;
    logic             cmp_exc = 1'b0;
    logic             cmp_mispred = 1'b0;
    logic             commit_valid;
    logic [TAG_W-1:0] commit_tag;
    logic             exc_valid;
    logic [PC_W-1:0]  exc_pc;
    logic             flush;
    logic             restart = 1'b0;

    always #2 clk = ~clk;

    rob_core #(.DEPTH(DEPTH), .TAG_W(TAG_W), .PC_W(PC_W)) dut (
        .clk(clk), .rst_n(rst_n),
        .alloc_valid(alloc_valid), .alloc_tag(alloc_tag), .alloc_pc(alloc_pc),
        .alloc_ready(alloc_ready),
        .cmp_valid(cmp_valid), .cmp_tag(cmp_tag), .cmp_exc(cmp_exc),
        .cmp_mispred(cmp_mispred),
        .commit_valid(commit_valid), .commit_tag(commit_tag),
        .exc_valid(exc_valid), .exc_pc(exc_pc), .flush(flush),
        .restart(restart)
    );

    // behavioural model: a program-ordered queue
    typedef struct {
        logic [TAG_W-1:0] tag;
        logic [PC_W-1:0]  pc;
        bit               done;
        bit               exc;
    } ment_t;

    ment_t mq[$];
    int checks = 0;
    int fails  = 0;
    int nt     = 1;
    int unsigned lcg = 32'h1234_5678;

    task automatic chk(string req, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic set_alloc();
        alloc_valid = 1'b1;
        alloc_tag   = TAG_W'(nt);
        alloc_pc    = PC_W'(32'h1000 + nt * 4);
    endtask

    task automatic set_cmp(int tag, bit exc, bit mis);
        cmp_valid   = 1'b1;
        cmp_tag     = TAG_W'(tag);
        cmp_exc     = exc;
        cmp_mispred = mis;
    endtask

    // one clock: compare outputs with the model, then advance the model
    task automatic cyc(string req);
        bit e_exc, e_com, e_flush, e_ready;
        int k;
        #1;
        k = -1;
        if (cmp_valid) begin
            foreach (mq[i]) if (k < 0 && mq[i].tag == cmp_tag) k = i;
        end
        e_exc   = (mq.size() > 0) && mq[0].done && mq[0].exc;
        e_com   = (mq.size() > 0) && mq[0].done && !mq[0].exc;
        e_flush = cmp_valid && (k >= 0) && cmp_mispred;
        e_ready = !e_exc && !e_flush && ((mq.size() < DEPTH) || e_com);
        chk(req, "alloc_ready", alloc_ready, e_ready);
        chk(req, "commit_valid", commit_valid, e_com);
        if (e_com) chk(req, "commit_tag", commit_tag, mq[0].tag);
        chk(req, "exc_valid", exc_valid, e_exc);
        if (e_exc) chk(req, "exc_pc", exc_pc, mq[0].pc);
        chk(req, "flush", flush, e_flush);
        @(posedge clk);
        if (restart) begin
            mq.delete();
        end else begin
            if (k >= 0) begin
                mq[k].done = 1'b1;
                mq[k].exc  = mq[k].exc | cmp_exc;
                if (e_flush) begin
                    while (mq.size() > k + 1) void'(mq.pop_back());
                end
            end
            if (e_com) void'(mq.pop_front());
            if (alloc_valid && e_ready) begin
                mq.push_back('{alloc_tag, alloc_pc, 1'b0, 1'b0});
                nt++;
            end
        end
        @(negedge clk);
        alloc_valid = 1'b0;
        cmp_valid   = 1'b0;
        cmp_exc     = 1'b0;
        cmp_mispred = 1'b0;
        restart     = 1'b0;
    endtask

    task automatic idle(int n, string req);
        for (int i = 0; i < n; i++) cyc(req);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #(200000 * 4);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        idle(2, "R1");

        // R2: fill to capacity (tags 1..8), then one refused offer
        for (int i = 0; i < DEPTH; i++) begin
            set_alloc();
            cyc("R2");
        end
        set_alloc();
        cyc("R2");

        // R4: complete the oldest
        set_cmp(1, 1'b0, 1'b0);
        cyc("R4");
        // R10: full buffer, retire and accept together (tag 9)
        set_alloc();
        cyc("R10");

        // R3: out-of-order completions retire in order
        set_cmp(4, 1'b0, 1'b0); cyc("R3");
        set_cmp(3, 1'b0, 1'b0); cyc("R3");
        cyc("R3");
        set_cmp(2, 1'b0, 1'b0); cyc("R3");
        idle(3, "R3");

        // R4: unknown tag changes nothing
        set_cmp(60, 1'b0, 1'b0);
        cyc("R4");

        // R8 + R9: branch tag 6 mispredicts while dispatch offers
        set_alloc();
        set_cmp(6, 1'b0, 1'b1);
        cyc("R9");
        // R8: stale completion of a squashed tag
        set_cmp(7, 1'b0, 1'b0);
        cyc("R8");
        set_alloc(); cyc("R8");
        set_alloc(); cyc("R8");
        set_cmp(5, 1'b0, 1'b0);
        cyc("R8");
        idle(3, "R8");
        set_cmp(nt - 1, 1'b0, 1'b0); cyc("R8");
        set_cmp(nt - 2, 1'b0, 1'b0); cyc("R8");
        idle(3, "R8");

        // R5: fault on a younger entry stays silent until it is oldest
        set_alloc(); cyc("R5");
        set_alloc(); cyc("R5");
        set_alloc(); cyc("R5");
        set_cmp(nt - 2, 1'b1, 1'b0); cyc("R5");
        idle(1, "R5");
        set_cmp(nt - 3, 1'b0, 1'b0); cyc("R5");
        idle(2, "R5");
        // R6: frozen while trapped
        set_alloc(); cyc("R6");
        set_cmp(nt - 1, 1'b0, 1'b0); cyc("R6");
        idle(2, "R6");

        // R7: restart empties everything
        restart = 1'b1;
        cyc("R7");
        idle(2, "R7");
        set_alloc(); cyc("R7");
        set_cmp(nt - 1, 1'b0, 1'b0); cyc("R7");
        idle(2, "R7");

        // mixed traffic across pointer wrap: R3, R8, R5, R7
        for (int n = 0; n < 1500; n++) begin
            int idx;
            lcg = lcg * 32'd1664525 + 32'd1013904223;
            if (lcg[1] | lcg[2]) set_alloc();
            if (mq.size() > 0 && lcg[4:3] != 2'b00) begin
                idx = int'(lcg[15:8]) % mq.size();
                if (!mq[idx].done) set_cmp(int'(mq[idx].tag), lcg[21:17] == 5'd0, lcg[25:22] == 4'd0);
            end
            if (mq.size() > 0 && mq[0].done && mq[0].exc && lcg[27]) begin
                alloc_valid = 1'b0;
                cmp_valid   = 1'b0;
                restart     = 1'b1;
                cyc("R7");
            end else begin
                cyc("R3");
            end
        end

        finish_run();
    end

endmodule